// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Memory

This block is a single-port store of 32-bit words. Each word is kept together with a 7-bit check code produced by a fixed parity matrix. Every data column of that matrix has weight three. A write computes the code and stores it beside the data. A read recomputes the code from the stored data and XORs it with the stored code to form a syndrome. The syndrome decides one of three outcomes: the word is clean, one bit is corrected, or the word is reported as uncorrectable. Each outcome is reported on a one-cycle pulse that goes with the read response.

Three control levels govern the memory:
- **Protection enable:** gates both code generation and checking.
- **Checking enable:** switches correction and reporting off for raw access.
- **Injection enable:** makes a write store a supplied check code instead of the computed one. A companion select changes this to storing the computed code XORed with the supplied value.

The usual recovery sequence is to read a word with checking off and write it back. The write-back stores a fresh, correct code. Interrupt delivery, the status register and any bus protocol live elsewhere.

A small controller tracks the response cycle. It has two states:
- **ST_IDLE:** no response is pending.
- **ST_RESP:** the read result is being presented.

Its transitions are:
- **T_RD_ISSUE:** ST_IDLE to ST_RESP, taken when a read is requested.
- **T_RD_CHAIN:** ST_RESP to ST_RESP, taken when another read is requested.
- **T_RESP_DONE:** ST_RESP to ST_IDLE, taken when no read is requested.

Top module: `secded_lmem`

## Requirements
- R1: After reset, rsp_valid, err_single and err_double are 0.
- R2: Check bit k is the XOR of the data bits in its set. Bit 0 uses {0,1,3,4,6,8,10,12,14,17,19,20,24,28}. Bit 1 uses {0,2,3,5,6,9,11,12,15,20,22,25,29}. Bit 2 uses {1,2,3,7,8,9,13,14,15,18,21,22,26,30}. Bit 3 uses {4..9,16..18,23..26,31}. Bit 4 uses {10..18,27..31}. Bit 5 uses {19..31}. Bit 6 uses {0,1,2,4,5,7,10,11,13,16,19,21,23,27}. A word written normally reads back unchanged with no error pulse.
- R3: With ecc_en=1, inj_en=1 and inj_xor=0, a write stores inj_code as the check code.
- R4: With ecc_en=1, inj_en=1 and inj_xor=1, a write stores the computed code XOR inj_code.
- R5: If the syndrome (recomputed code XOR stored code) equals the column of data bit j, bit j of rsp_rdata is inverted and err_single pulses.
- R6: A syndrome with exactly one bit set is a check-bit error: err_single pulses and the data is returned unchanged.
- R7: A nonzero syndrome of even weight raises err_double, returns the stored data uncorrected, and never coincides with err_single.
- R8: A nonzero odd-weight syndrome that matches no data column and is not weight one (for example 0x62 or 0x7F) raises err_double with the data uncorrected.
- R9: A read requested with chk_en=0 or ecc_en=0 returns the raw stored data with no error pulse.
- R10: Reading a damaged word with checking off and then writing it back restores the word, so a later checked read is clean.
- R11: A write with ecc_en=0 stores an all-zero check code.
- R12: rsp_valid is high in exactly the cycle after each read request, and a write never produces a response.
- R13: Injection has no effect on a write made with ecc_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| ecc_en | input | 1 | Protection enable |
| chk_en | input | 1 | Checking enable |
| inj_en | input | 1 | Injection enable |
| inj_xor | input | 1 | Injection XORs into the computed code instead of replacing it |
| inj_code | input | 7 | Supplied check code |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 32 | Read data, corrected when checking applies |
| err_single | output | 1 | Corrected error pulse |
| err_double | output | 1 | Uncorrectable error pulse |

## Verification
A read response and a new write can occupy the same cycle. The response to a read is presented while the next request, a write, is already being accepted by the array. The bench provokes this by issuing a write to a second word in the very cycle it samples the first read's result. It judges the outcome in two ways. The reported data and pulses must belong to the earlier read alone. Later reads of both words must show the write landed with a correct code and did not disturb the first word.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
    localparam int DATA_W = 32;
    localparam int CODE_W = 7;
    localparam int WORD_W = DATA_W + CODE_W;

    // Parity set of each check bit, as a data-bit mask
    localparam logic [DATA_W-1:0] CHK_SET [CODE_W] = '{
        32'h111A555B, 32'h22509A6D, 32'h4464E38E, 32'h878703F0,
        32'hF807FC00, 32'hFFF80000, 32'h08A92CB7
    };

    typedef enum logic {ST_IDLE, ST_RESP} resp_state_t;

    typedef enum logic [1:0] {OUT_CLEAN, OUT_FIXED, OUT_FATAL} dec_kind_t;

    function automatic logic [CODE_W-1:0] ecc_gen(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        for (int k = 0; k < CODE_W; k++) c[k] = ^(d & CHK_SET[k]);
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] ecc_col(input int j);
        logic [CODE_W-1:0] c;
        for (int k = 0; k < CODE_W; k++) c[k] = CHK_SET[k][j];
        return c;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_mem_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic              ecc_en_i,
    input  logic              inj_en_i,
    input  logic              inj_xor_i,
    input  logic [CODE_W-1:0] inj_code_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] gen_code;

    assign gen_code = ecc_gen(data_i);

    always_comb begin
        if (!ecc_en_i) begin
            code_o = '0;
        end else if (inj_en_i) begin
            code_o = inj_xor_i ? (gen_code ^ inj_code_i) : inj_code_i;
        end else begin
            code_o = gen_code;
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_mem_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output dec_kind_t         kind_o
);
    logic [CODE_W-1:0] syndrome;
    logic [DATA_W-1:0] flip_mask;

    assign syndrome = ecc_gen(data_i) ^ code_i;

    // One comparator per data column
    genvar j;
    generate
        for (j = 0; j < DATA_W; j++) begin : g_col
            assign flip_mask[j] = (syndrome == ecc_col(j));
        end
    endgenerate

    always_comb begin
        data_o = data_i;
        if (syndrome == '0) begin
            kind_o = OUT_CLEAN;
        end else if (flip_mask != '0) begin
            kind_o = OUT_FIXED;
            data_o = data_i ^ flip_mask;
        end else if ($countones(syndrome) == 1) begin
            kind_o = OUT_FIXED;
        end else begin
            kind_o = OUT_FATAL;
        end
    end
endmodule

// File: rtl/ecc_mem_array.sv
module ecc_mem_array #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 39,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wword,
    output logic [WIDTH-1:0] rword
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[addr] <= wword;
        if (rd_en) rword <= store[addr];
    end
endmodule

// File: rtl/secded_lmem.sv
module secded_lmem
    import ecc_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ecc_en,
    input  logic              chk_en,
    input  logic              inj_en,
    input  logic              inj_xor,
    input  logic [CODE_W-1:0] inj_code,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_single,
    output logic              err_double
);
    resp_state_t       state_q, state_d;
    logic              chk_q;
    logic              rd_go, wr_go;
    logic [CODE_W-1:0] wr_code;
    logic [WORD_W-1:0] rd_word;
    logic [DATA_W-1:0] fixed_data;
    dec_kind_t         kind;

    assign rd_go = req_valid && !req_write;
    assign wr_go = req_valid && req_write;

    ecc_encoder u_enc (
        .data_i     (req_wdata),
        .ecc_en_i   (ecc_en),
        .inj_en_i   (inj_en),
        .inj_xor_i  (inj_xor),
        .inj_code_i (inj_code),
        .code_o     (wr_code)
    );

    ecc_mem_array #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_arr (
        .clk   (clk),
        .wr_en (wr_go),
        .rd_en (rd_go),
        .addr  (req_addr),
        .wword ({wr_code, req_wdata}),
        .rword (rd_word)
    );

    ecc_decoder u_dec (
        .data_i (rd_word[DATA_W-1:0]),
        .code_i (rd_word[WORD_W-1:DATA_W]),
        .data_o (fixed_data),
        .kind_o (kind)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_go) state_d = ST_RESP;           // T_RD_ISSUE
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;    // T_RD_CHAIN / T_RESP_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the check mode captured with the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_go) chk_q <= ecc_en && chk_en;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_rdata  = '0;
        err_single = 1'b0;
        err_double = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (chk_q) begin
                    rsp_rdata  = fixed_data;
                    err_single = (kind == OUT_FIXED);
                    err_double = (kind == OUT_FATAL);
                end else begin
                    rsp_rdata = rd_word[DATA_W-1:0];
                end
            end
            default: ;
        endcase
    end

    // R12
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
    // R12
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);
    // R9
    err_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_single || err_double) |-> $past(ecc_en && chk_en));
    // R7
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));
endmodule

// File: tb/sim_secded_lmem.sv
module sim_secded_lmem;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic ecc_en = 1'b1, chk_en = 1'b1, inj_en = 1'b0, inj_xor = 1'b0;
    logic [6:0] inj_code = '0;
    logic rsp_valid, err_single, err_double;
    logic [31:0] rsp_rdata;

    int n_chk = 0, n_err = 0;
    logic [31:0] got_d;
    logic got_v, got_s, got_x;

    always #2.5 clk = ~clk;

    secded_lmem #(.DEPTH(DEPTH)) u0 (.*);

    // Model of the parity sets, written from R2
    function automatic logic [6:0] mcode(input logic [31:0] d);
        logic [31:0] m [7];
        logic [6:0] c;
        m[0] = 32'h111A555B; m[1] = 32'h22509A6D; m[2] = 32'h4464E38E;
        m[3] = 32'h878703F0; m[4] = 32'hF807FC00; m[5] = 32'hFFF80000;
        m[6] = 32'h08A92CB7;
        for (int k = 0; k < 7; k++) c[k] = ^(d & m[k]);
        return c;
    endfunction

    function automatic logic [6:0] mcol(input int j);
        return mcode(32'h1 << j);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input bit e, input bit ij, input bit x, input logic [6:0] ic);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
        ecc_en = e; inj_en = ij; inj_xor = x; inj_code = ic;
        @(negedge clk);
        req_valid = 0; inj_en = 0; ecc_en = 1;
    endtask

    task automatic rd(input int a, input bit e, input bit c);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a); ecc_en = e; chk_en = c;
        @(negedge clk);
        req_valid = 0; ecc_en = 1; chk_en = 1;
        got_v = rsp_valid; got_d = rsp_rdata; got_s = err_single; got_x = err_double;
    endtask

    task automatic expect_rd(input string req, input logic [31:0] d, input bit s, input bit x);
        check(got_v && got_d == d && got_s == s && got_x == x, req,
              {29'd0, got_v, got_s, got_x, got_d}, {29'd0, 1'b1, s, x, d});
    endtask

    task automatic t_reset;
        check(!rsp_valid && !err_single && !err_double, "R1",
              {rsp_valid, err_single, err_double}, 3'b000);
    endtask

    task automatic t_plain;
        logic [31:0] pats [3];
        pats[0] = 32'hDEADBEEF; pats[1] = 32'h0; pats[2] = 32'hFFFFFFFF;
        for (int i = 0; i < 3; i++) begin
            wr(i, pats[i], 1, 0, 0, 0);
            rd(i, 1, 1);
            expect_rd("R2", pats[i], 0, 0);
        end
        // Stored code equal to the model code reads clean: confirms the sets
        wr(5, 32'h13579BDF, 1, 1, 0, mcode(32'h13579BDF));
        rd(5, 1, 1);
        expect_rd("R2/R3", 32'h13579BDF, 0, 0);
    endtask

    task automatic t_inject;
        logic [31:0] d = 32'hA5C3_0F96;
        wr(6, d, 1, 1, 0, mcode(d) ^ 7'h01);
        rd(6, 1, 1);
        expect_rd("R3/R6", d, 1, 0);
        wr(6, d, 1, 1, 1, 7'h10);
        rd(6, 1, 1);
        expect_rd("R4/R6", d, 1, 0);
        wr(6, d, 1, 1, 1, 7'h03);
        rd(6, 1, 1);
        expect_rd("R7", d, 0, 1);
        wr(6, d, 1, 1, 1, 7'h7F);
        rd(6, 1, 1);
        expect_rd("R8 w7", d, 0, 1);
        wr(6, d, 1, 1, 1, 7'h62);
        rd(6, 1, 1);
        expect_rd("R8 w3", d, 0, 1);
    endtask

    task automatic t_correct;
        int cols [3];
        logic [31:0] d = 32'h5A5A_1234;
        cols[0] = 0; cols[1] = 17; cols[2] = 31;
        for (int i = 0; i < 3; i++) begin
            wr(7, d, 1, 1, 1, mcol(cols[i]));
            rd(7, 1, 1);
            expect_rd("R5", d ^ (32'h1 << cols[i]), 1, 0);
        end
    endtask

    task automatic t_restore;
        logic [31:0] d = 32'h0BAD_F00D;
        wr(8, d, 1, 1, 1, 7'h05);
        rd(8, 1, 1);
        expect_rd("R10 damaged", d, 0, 1);
        rd(8, 1, 0);
        expect_rd("R9", d, 0, 0);
        rd(8, 0, 1);
        expect_rd("R9 ecc off", d, 0, 0);
        wr(8, got_d, 1, 0, 0, 0);
        rd(8, 1, 1);
        expect_rd("R10", d, 0, 0);
    endtask

    task automatic t_ecc_off;
        wr(9, 32'h1, 0, 0, 0, 0);
        rd(9, 0, 1);
        expect_rd("R11 raw", 32'h1, 0, 0);
        // Zero code against data 1 gives syndrome = column of bit 0
        rd(9, 1, 1);
        expect_rd("R11", 32'h0, 1, 0);
        wr(10, 32'h0, 0, 1, 0, 7'h55);
        rd(10, 1, 1);
        expect_rd("R13", 32'h0, 0, 0);
    endtask

    task automatic t_timing;
        wr(11, 32'hCAFE_0001, 1, 0, 0, 0);
        check(!rsp_valid, "R12 write", rsp_valid, 0);
        rd(11, 1, 1);
        expect_rd("R12 read", 32'hCAFE_0001, 0, 0);
        @(negedge clk);
        check(!rsp_valid, "R12 single", rsp_valid, 0);
    endtask

    task automatic t_overlap;
        wr(12, 32'h1111_2222, 1, 1, 1, 7'h03);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 12;
        @(negedge clk);
        // Response of the read while a write to another word is issued
        got_v = rsp_valid; got_d = rsp_rdata; got_s = err_single; got_x = err_double;
        req_write = 1; req_addr = 13; req_wdata = 32'h3333_4444;
        @(negedge clk);
        req_valid = 0;
        expect_rd("R7 overlap", 32'h1111_2222, 0, 1);
        check(!rsp_valid, "R12 overlap", rsp_valid, 0);
        rd(13, 1, 1);
        expect_rd("R2 overlap", 32'h3333_4444, 0, 0);
        rd(12, 1, 1);
        expect_rd("R7 kept", 32'h1111_2222, 0, 1);
    endtask

    initial begin
        #1;
        t_reset;
        #20 rst_n = 1;
        @(negedge clk);
        t_reset;
        t_plain;
        t_inject;
        t_correct;
        t_restore;
        t_ecc_off;
        t_timing;
        t_overlap;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule